// File: doc/BRIEF.md
# Kernel Instance Dispatcher

This block sits behind a command parser. It takes one launch request at a time and hands out kernel instances to a pool of hardware threads. For a kernel launch it gives out instance numbers 0 through N-1, one per cycle, to idle threads. Each thread gets a one-cycle start strobe and its own instance number. All threads share the latched entry address, stack top, return address and argument slots. A thread reports that it has finished with a one-cycle done strobe.

There are two kernel launch types. The slice launch puts a slice identifier in the first argument slot. It also requests a flush of both caches after the last instance finishes and waits for the acknowledge before it completes. The variable-argument launch passes up to seven extra arguments in order and completes without a flush. A third request type, the cache sync, starts no thread and only runs a flush of the caches its flags select.

A per-request thread cap limits which threads may take instances. The block finishes every request with a single-cycle completion pulse.

Top module: `kernel_dispatch`

## Requirements
- R1: For a kernel launch with count N, each instance number 0..N-1 is started exactly once. Numbers are handed out in increasing order, with at most one start strobe per cycle.
- R2: Each instance goes to the lowest-numbered idle thread that the cap allows. With all threads idle, instance i goes to thread i.
- R3: `hart_limit` L restricts work to threads 0..L-1. L = 0, or L at least the thread count, allows every thread.
- R4: `launch_kind` encoding: 1 = slice launch, 2 = cache sync, 0 or 3 = variable-argument launch. For a variable-argument launch, `arg_count` K (0..7) makes argument slots 0..K-1 carry extra arguments 0..K-1 in order, and the other slots read zero. Slot s occupies bits [64s+63:64s].
- R5: For a slice launch, slot 0 carries `slice_id` and all other slots read zero.
- R6: A slice launch raises `flush_req` with `flush_sel` = 2'b11 only after every instance has finished. It holds the request until `flush_ack`, and no start strobe occurs while the request is high.
- R7: A variable-argument launch completes without raising `flush_req`.
- R8: A cache sync starts no thread. It raises `flush_req` with `flush_sel` = `sync_flags` (bit 0 = data cache, bit 1 = instruction cache). With flags 2'b00 it completes without a flush.
- R9: A kernel launch with count 0 starts no thread, requests no flush and completes.
- R10: `launch_done` is high for exactly one cycle per request. It comes only after all instances have finished and any required acknowledge has arrived. `launch_ready` is low from acceptance until after that pulse.
- R11: After reset: `launch_ready` is 1, and `launch_done`, `thr_start` and `flush_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| launch_valid | input | 1 | Request present; accepted when `launch_ready` is high |
| launch_ready | output | 1 | Dispatcher idle |
| launch_kind | input | 2 | Request type |
| hart_limit | input | 8 | Thread cap |
| arg_count | input | 3 | Number of extra arguments |
| sync_flags | input | 2 | Cache selection for a sync |
| inst_total | input | ID_W | Instance count |
| slice_id | input | DATA_W | Slice identifier |
| extra_args | input | 7*DATA_W | Extra arguments, slot-packed |
| entry_addr | input | DATA_W | Kernel entry address |
| stack_top | input | DATA_W | Stack top |
| return_addr | input | DATA_W | Return address |
| job_entry | output | DATA_W | Latched entry address |
| job_stack | output | DATA_W | Latched stack top |
| job_return | output | DATA_W | Latched return address |
| job_args | output | 7*DATA_W | Latched argument slots |
| thr_start | output | NUM_THREADS | Per-thread start strobe |
| thr_inst_id | output | NUM_THREADS*ID_W | Per-thread instance number |
| thr_done | input | NUM_THREADS | Per-thread finish strobe |
| flush_req | output | 1 | Cache flush request |
| flush_sel | output | 2 | Caches to flush |
| flush_ack | input | 1 | Flush acknowledge |
| launch_done | output | 1 | Completion pulse |

## Verification
The assertions assume that a thread raises its done strobe only once per start and only after that start. They also assume that `flush_ack` arrives only while `flush_req` is high. The bench's thread models and flush responder meet both assumptions: each waits for its own strobe, pulses for one cycle and then returns to waiting. Requests are driven only while `launch_ready` is high, so the thread cap latched by the checker always belongs to the request that is running.

// File: rtl/kd_pkg.sv
package kd_pkg;

    typedef enum logic [1:0] {
        LK_VARARG = 2'd0,
        LK_SLICE  = 2'd1,
        LK_SYNC   = 2'd2,
        LK_RSVD   = 2'd3
    } launch_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FLUSH,
        ST_FIN
    } disp_state_e;

    localparam int          XARG_SLOTS = 7;
    localparam int          CSEL_W     = 2;
    localparam logic [1:0]  CSEL_ALL   = 2'b11;

    typedef struct packed {
        launch_kind_e        kind;
        logic [CSEL_W-1:0]   csel;
    } job_ctl_t;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/kd_pick.sv
module kd_pick
    import kd_pkg::*;
#(
    parameter int NT = 4,
    localparam int IDX_W = idx_width(NT)
) (
    input  logic [NT-1:0]    idle_mask,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = NT - 1; k >= 0; k--) begin
            if (idle_mask[k]) begin
                found = 1'b1;
                idx   = IDX_W'(k);
            end
        end
    end
endmodule

// File: rtl/kd_thread_track.sv
module kd_thread_track
    import kd_pkg::*;
#(
    parameter int NT   = 4,
    parameter int ID_W = 16,
    localparam int IDX_W = idx_width(NT),
    localparam int CNT_W = $clog2(NT + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     assign_en,
    input  logic [IDX_W-1:0]         assign_idx,
    input  logic [ID_W-1:0]          assign_id,
    input  logic [NT-1:0]            thr_done,
    output logic [NT-1:0]            busy,
    output logic [NT-1:0]            start,
    output logic [NT-1:0][ID_W-1:0]  inst_id,
    output logic [CNT_W-1:0]         finish_cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= '0;
            start   <= '0;
            inst_id <= '0;
        end else begin
            for (int k = 0; k < NT; k++) begin
                start[k] <= 1'b0;
                if (assign_en && (assign_idx == IDX_W'(k))) begin
                    busy[k]    <= 1'b1;
                    start[k]   <= 1'b1;
                    inst_id[k] <= assign_id;
                end else if (thr_done[k] && busy[k]) begin
                    busy[k] <= 1'b0;
                end
            end
        end
    end

    assign finish_cnt = CNT_W'($countones(busy & thr_done));
endmodule

// File: rtl/kd_arg_pack.sv
module kd_arg_pack
    import kd_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  launch_kind_e                    kind,
    input  logic [2:0]                      arg_count,
    input  logic [DATA_W-1:0]               slice_id,
    input  logic [XARG_SLOTS*DATA_W-1:0]    extra_in,
    output logic [XARG_SLOTS*DATA_W-1:0]    slots_out
);
    for (genvar s = 0; s < XARG_SLOTS; s++) begin : g_slot
        always_comb begin
            unique case (kind)
                LK_SLICE: slots_out[s*DATA_W +: DATA_W] = (s == 0) ? slice_id : '0;
                LK_SYNC:  slots_out[s*DATA_W +: DATA_W] = '0;
                default:  slots_out[s*DATA_W +: DATA_W] =
                              (3'(s) < arg_count) ? extra_in[s*DATA_W +: DATA_W] : '0;
            endcase
        end
    end
endmodule

// File: rtl/kernel_dispatch.sv
module kernel_dispatch
    import kd_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int ID_W        = 16,
    parameter int DATA_W      = 64
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             launch_valid,
    output logic                             launch_ready,
    input  logic [1:0]                       launch_kind,
    input  logic [7:0]                       hart_limit,
    input  logic [2:0]                       arg_count,
    input  logic [1:0]                       sync_flags,
    input  logic [ID_W-1:0]                  inst_total,
    input  logic [DATA_W-1:0]                slice_id,
    input  logic [7*DATA_W-1:0]              extra_args,
    input  logic [DATA_W-1:0]                entry_addr,
    input  logic [DATA_W-1:0]                stack_top,
    input  logic [DATA_W-1:0]                return_addr,
    output logic [DATA_W-1:0]                job_entry,
    output logic [DATA_W-1:0]                job_stack,
    output logic [DATA_W-1:0]                job_return,
    output logic [7*DATA_W-1:0]              job_args,
    output logic [NUM_THREADS-1:0]           thr_start,
    output logic [NUM_THREADS*ID_W-1:0]      thr_inst_id,
    input  logic [NUM_THREADS-1:0]           thr_done,
    output logic                             flush_req,
    output logic [1:0]                       flush_sel,
    input  logic                             flush_ack,
    output logic                             launch_done
);
    localparam int IDX_W = idx_width(NUM_THREADS);
    localparam int CNT_W = $clog2(NUM_THREADS + 1);

    disp_state_e                       state_q;
    job_ctl_t                          ctl_q;
    logic [ID_W-1:0]                   total_q;
    logic [ID_W-1:0]                   next_q;
    logic [ID_W-1:0]                   comp_q;
    logic [NUM_THREADS-1:0]            allow_q;
    logic [NUM_THREADS-1:0]            allow_in;
    logic [7*DATA_W-1:0]               slots_in;

    logic [NUM_THREADS-1:0]            busy;
    logic [NUM_THREADS-1:0][ID_W-1:0]  inst_arr;
    logic [CNT_W-1:0]                  finish_cnt;
    logic                              found;
    logic [IDX_W-1:0]                  pick_idx;
    logic                              dispatch;
    logic [ID_W-1:0]                   comp_next;
    launch_kind_e                      kind_in;

    assign kind_in = launch_kind_e'(launch_kind);

    // cap mask for the incoming request
    for (genvar k = 0; k < NUM_THREADS; k++) begin : g_allow
        assign allow_in[k] = (hart_limit == 8'd0) || (32'(k) < 32'(hart_limit));
    end

    kd_arg_pack #(.DATA_W(DATA_W)) u_pack (
        .kind      (kind_in),
        .arg_count (arg_count),
        .slice_id  (slice_id),
        .extra_in  (extra_args),
        .slots_out (slots_in)
    );

    kd_pick #(.NT(NUM_THREADS)) u_pick (
        .idle_mask (~busy & allow_q),
        .found     (found),
        .idx       (pick_idx)
    );

    assign dispatch  = (state_q == ST_RUN) && (next_q != total_q) && found;
    assign comp_next = comp_q + ID_W'(finish_cnt);

    kd_thread_track #(.NT(NUM_THREADS), .ID_W(ID_W)) u_track (
        .clk        (clk),
        .rst        (rst),
        .assign_en  (dispatch),
        .assign_idx (pick_idx),
        .assign_id  (next_q),
        .thr_done   (thr_done),
        .busy       (busy),
        .start      (thr_start),
        .inst_id    (inst_arr),
        .finish_cnt (finish_cnt)
    );

    assign thr_inst_id = inst_arr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            ctl_q      <= '{kind: LK_VARARG, csel: '0};
            total_q    <= '0;
            next_q     <= '0;
            comp_q     <= '0;
            allow_q    <= '0;
            job_entry  <= '0;
            job_stack  <= '0;
            job_return <= '0;
            job_args   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (launch_valid) begin
                        ctl_q.kind <= kind_in;
                        ctl_q.csel <= (kind_in == LK_SLICE) ? CSEL_ALL :
                                      (kind_in == LK_SYNC)  ? sync_flags : '0;
                        total_q    <= inst_total;
                        next_q     <= '0;
                        comp_q     <= '0;
                        allow_q    <= allow_in;
                        job_entry  <= entry_addr;
                        job_stack  <= stack_top;
                        job_return <= return_addr;
                        job_args   <= slots_in;
                        if (kind_in == LK_SYNC)
                            state_q <= (sync_flags != 2'b00) ? ST_FLUSH : ST_FIN;
                        else if (inst_total == '0)
                            state_q <= ST_FIN;
                        else
                            state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (dispatch) next_q <= next_q + 1'b1;
                    comp_q <= comp_next;
                    if (comp_next == total_q)
                        state_q <= (ctl_q.kind == LK_SLICE) ? ST_FLUSH : ST_FIN;
                end
                ST_FLUSH: begin
                    if (flush_ack) state_q <= ST_FIN;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign launch_ready = (state_q == ST_IDLE);
    assign launch_done  = (state_q == ST_FIN);
    assign flush_req    = (state_q == ST_FLUSH);
    assign flush_sel    = ctl_q.csel;
endmodule

// File: rtl/kd_checker.sv
module kd_checker #(
    parameter int NUM_THREADS = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   launch_valid,
    input logic                   launch_ready,
    input logic [7:0]             hart_limit,
    input logic [NUM_THREADS-1:0] thr_start,
    input logic                   flush_req,
    input logic [1:0]             flush_sel,
    input logic                   flush_ack,
    input logic                   launch_done
);
    logic [7:0]             lim_q;
    logic [NUM_THREADS-1:0] allow;

    always_ff @(posedge clk) begin
        if (rst) lim_q <= 8'd0;
        else if (launch_valid && launch_ready) lim_q <= hart_limit;
    end

    always_comb begin
        for (int k = 0; k < NUM_THREADS; k++)
            allow[k] = (lim_q == 8'd0) || (32'(k) < 32'(lim_q));
    end

    AST_ONE_START: assert property (@(posedge clk) disable iff (rst)
        $countones(thr_start) <= 1); // R1
    AST_HART_CAP: assert property (@(posedge clk) disable iff (rst)
        (thr_start & ~allow) == '0); // R3
    AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (thr_start != '0) |-> !launch_ready); // R10
    AST_FLUSH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (flush_req && !flush_ack) |=> flush_req); // R6
    AST_NO_START_IN_FLUSH: assert property (@(posedge clk) disable iff (rst)
        flush_req |-> (thr_start == '0)); // R6
    AST_FLUSH_SEL_STABLE: assert property (@(posedge clk) disable iff (rst)
        (flush_req && $past(flush_req)) |-> $stable(flush_sel)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        launch_done |=> !launch_done); // R10
    AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        launch_done |=> launch_ready); // R10
    AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        launch_done |-> !launch_ready); // R10
endmodule

bind kernel_dispatch kd_checker #(.NUM_THREADS(NUM_THREADS)) u_kd_checker (
    .clk          (clk),
    .rst          (rst),
    .launch_valid (launch_valid),
    .launch_ready (launch_ready),
    .hart_limit   (hart_limit),
    .thr_start    (thr_start),
    .flush_req    (flush_req),
    .flush_sel    (flush_sel),
    .flush_ack    (flush_ack),
    .launch_done  (launch_done)
);

// File: tb/kernel_dispatch_bench.sv
module kernel_dispatch_bench;
    localparam int CLK_PERIOD = 10;
    localparam int T   = 4;
    localparam int IW  = 16;
    localparam int DW  = 64;
    localparam int MAXI = 64;

    typedef struct packed {
        logic [1:0]  kind;
        logic [7:0]  lim;
        logic [15:0] total;
        logic [2:0]  argc;
        logic [3:0]  dly;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [0:NV-1] = '{
        '{2'd0, 8'd0,   16'd10, 3'd3, 4'd2},
        '{2'd0, 8'd2,   16'd7,  3'd7, 4'd1},
        '{2'd1, 8'd1,   16'd5,  3'd0, 4'd0},
        '{2'd1, 8'd3,   16'd12, 3'd2, 4'd3},
        '{2'd3, 8'd200, 16'd9,  3'd0, 4'd5},
        '{2'd1, 8'd4,   16'd1,  3'd5, 4'd1}
    };

    logic             clk = 0;
    logic             rst = 1;
    logic             launch_valid = 0;
    logic             launch_ready;
    logic [1:0]       launch_kind = 0;
    logic [7:0]       hart_limit = 0;
    logic [2:0]       arg_count = 0;
    logic [1:0]       sync_flags = 0;
    logic [IW-1:0]    inst_total = 0;
    logic [DW-1:0]    slice_id = 0;
    logic [7*DW-1:0]  extra_args = 0;
    logic [DW-1:0]    entry_addr = 0, stack_top = 0, return_addr = 0;
    logic [DW-1:0]    job_entry, job_stack, job_return;
    logic [7*DW-1:0]  job_args;
    logic [T-1:0]     thr_start;
    logic [T*IW-1:0]  thr_inst_id;
    logic [T-1:0]     thr_done;
    logic             flush_req;
    logic [1:0]       flush_sel;
    logic             flush_ack;
    logic             launch_done;

    kernel_dispatch #(.NUM_THREADS(T), .ID_W(IW), .DATA_W(DW)) u_kernel_dispatch (
        .clk(clk), .rst(rst), .launch_valid(launch_valid), .launch_ready(launch_ready),
        .launch_kind(launch_kind), .hart_limit(hart_limit), .arg_count(arg_count),
        .sync_flags(sync_flags), .inst_total(inst_total), .slice_id(slice_id),
        .extra_args(extra_args), .entry_addr(entry_addr), .stack_top(stack_top),
        .return_addr(return_addr), .job_entry(job_entry), .job_stack(job_stack),
        .job_return(job_return), .job_args(job_args), .thr_start(thr_start),
        .thr_inst_id(thr_inst_id), .thr_done(thr_done), .flush_req(flush_req),
        .flush_sel(flush_sel), .flush_ack(flush_ack), .launch_done(launch_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int run_seq = 0;
    int dly = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // thread models
    int comp_arr [T];
    for (genvar k = 0; k < T; k++) begin : g_thr
        logic done_k;
        int   comp_k;
        assign thr_done[k]  = done_k;
        assign comp_arr[k]  = comp_k;
        initial begin
            done_k = 0;
            comp_k = 0;
            forever begin
                @(negedge clk);
                if (thr_start[k]) begin
                    repeat (dly + k) @(negedge clk);
                    done_k = 1;
                    comp_k++;
                    @(negedge clk);
                    done_k = 0;
                end
            end
        end
    end

    function automatic int comp_sum();
        int s = 0;
        for (int k = 0; k < T; k++) s += comp_arr[k];
        return s;
    endfunction

    // flush responder
    int         flush_cnt = 0;
    logic [1:0] flush_sel_seen = 0;
    initial begin
        flush_ack = 0;
        forever begin
            @(negedge clk);
            if (flush_req) begin
                repeat (2) @(negedge clk);
                flush_sel_seen = flush_sel;
                flush_ack = 1;
                flush_cnt++;
                @(negedge clk);
                flush_ack = 0;
            end
        end
    end

    // start / done monitor
    int mon_seq = 0;
    int seen [MAXI];
    int inst_thr [MAXI];
    int used [T];
    int next_expect, order_err, done_cnt, start_total;
    int done_comp, done_flush, done_seq;
    initial begin
        done_seq = 0;
        forever begin
            @(negedge clk);
            if (mon_seq != run_seq) begin
                mon_seq = run_seq;
                for (int i = 0; i < MAXI; i++) begin seen[i] = 0; inst_thr[i] = -1; end
                for (int k = 0; k < T; k++) used[k] = 0;
                next_expect = 0; order_err = 0; done_cnt = 0; start_total = 0;
            end
            for (int k = 0; k < T; k++) begin
                if (thr_start[k]) begin
                    int id;
                    id = int'(thr_inst_id[k*IW +: IW]);
                    if (id < MAXI) begin seen[id]++; inst_thr[id] = k; end
                    if (id != next_expect) order_err++;
                    next_expect++;
                    used[k]++;
                    start_total++;
                end
            end
            if (launch_done) begin
                done_cnt++;
                done_comp  = comp_sum();
                done_flush = flush_cnt;
                done_seq   = mon_seq;
            end
        end
    end

    function automatic logic [DW-1:0] xarg(input int v, input int s);
        return {32'hC0DE_0000 | 32'(v), 32'(s + 1)};
    endfunction

    int base_comp, base_flush;

    task automatic do_launch(input int v, input logic [1:0] kind, input logic [7:0] lim,
                             input logic [15:0] total, input logic [2:0] argc,
                             input logic [1:0] flags, input int d);
        int wd;
        @(negedge clk);
        while (!launch_ready) @(negedge clk);
        run_seq++;
        dly        = d;
        base_comp  = comp_sum();
        base_flush = flush_cnt;
        launch_kind = kind; hart_limit = lim; inst_total = total; arg_count = argc;
        sync_flags  = flags;
        slice_id    = 64'h5100_0000 + 64'(v);
        entry_addr  = 64'h8000_0000 + 64'(v);
        stack_top   = 64'h9000_0000 + 64'(v);
        return_addr = 64'hA000_0000 + 64'(v);
        for (int s = 0; s < 7; s++) extra_args[s*DW +: DW] = xarg(v, s);
        launch_valid = 1;
        @(negedge clk);
        launch_valid = 0;
        chk(!launch_ready, "R10", "ready low after accept", launch_ready, 0);
        wd = 0;
        while (done_seq != run_seq && wd < 3000) begin @(negedge clk); wd++; end
        chk(wd < 3000, "R10", "completion seen", wd, 0);
        repeat (3) @(negedge clk);
    endtask

    // global watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R10 watchdog expired: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        // reset state
        chk(launch_ready == 1, "R11", "ready after reset", launch_ready, 1);
        chk(launch_done == 0,  "R11", "done after reset", launch_done, 0);
        chk(thr_start == 0,    "R11", "start after reset", thr_start, 0);
        chk(flush_req == 0,    "R11", "flush after reset", flush_req, 0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            vec_t vc;
            int   eff;
            bit   is_slice;
            vc = VECS[v];
            is_slice = (vc.kind == 2'd1);
            eff = (vc.lim == 0 || int'(vc.lim) > T) ? T : int'(vc.lim);
            do_launch(v, vc.kind, vc.lim, vc.total, vc.argc, 2'b00, int'(vc.dly));
            // argument slots (sampled after completion; latched at accept)
            for (int s = 0; s < 7; s++) begin
                logic [DW-1:0] e;
                if (is_slice) e = (s == 0) ? (64'h5100_0000 + 64'(v)) : '0;
                else          e = (s < int'(vc.argc)) ? xarg(v, s) : '0;
                chk(job_args[s*DW +: DW] == e, is_slice ? "R5" : "R4", "arg slot",
                    longint'(job_args[s*DW +: DW]), longint'(e));
            end
            chk(job_entry == 64'h8000_0000 + 64'(v), "R4", "entry latched",
                longint'(job_entry), longint'(64'h8000_0000 + 64'(v)));
            begin
                int bad = 0;
                for (int i = 0; i < int'(vc.total); i++) if (seen[i] != 1) bad++;
                chk(bad == 0, "R1", "each id once", bad, 0);
            end
            chk(start_total == int'(vc.total), "R1", "start count", start_total, int'(vc.total));
            chk(order_err == 0, "R1", "increasing order", order_err, 0);
            begin
                int over = 0;
                for (int k = eff; k < T; k++) over += used[k];
                chk(over == 0, "R3", "threads beyond cap", over, 0);
            end
            chk(done_cnt == 1, "R10", "single done pulse", done_cnt, 1);
            chk(done_comp - base_comp == int'(vc.total), "R10", "all finished at done",
                done_comp - base_comp, int'(vc.total));
            if (is_slice) begin
                chk(done_flush - base_flush == 1, "R6", "flush before done",
                    done_flush - base_flush, 1);
                chk(flush_sel_seen == 2'b11, "R6", "flush both caches", flush_sel_seen, 3);
            end else begin
                chk(flush_cnt - base_flush == 0, "R7", "no flush", flush_cnt - base_flush, 0);
            end
        end

        // lowest idle thread gets each new instance
        do_launch(10, 2'd0, 8'd0, 16'd4, 3'd1, 2'b00, 12);
        for (int i = 0; i < 4; i++)
            chk(inst_thr[i] == i, "R2", "instance to thread", inst_thr[i], i);

        // cap of 2 with longer work: only threads 0 and 1
        do_launch(11, 2'd0, 8'd2, 16'd6, 3'd0, 2'b00, 4);
        chk(used[2] + used[3] == 0, "R3", "cap two", used[2] + used[3], 0);
        chk(used[0] > 0 && used[1] > 0, "R2", "both allowed threads used", used[1], 1);

        // zero instance count, slice type
        do_launch(12, 2'd1, 8'd0, 16'd0, 3'd0, 2'b00, 1);
        chk(start_total == 0, "R9", "no starts", start_total, 0);
        chk(flush_cnt - base_flush == 0, "R9", "no flush", flush_cnt - base_flush, 0);
        chk(done_cnt == 1, "R9", "done pulse", done_cnt, 1);

        // sync with data cache only
        do_launch(13, 2'd2, 8'd0, 16'd5, 3'd0, 2'b01, 1);
        chk(start_total == 0, "R8", "sync starts nothing", start_total, 0);
        chk(flush_cnt - base_flush == 1, "R8", "sync flush", flush_cnt - base_flush, 1);
        chk(flush_sel_seen == 2'b01, "R8", "sync selection", flush_sel_seen, 1);
        chk(done_cnt == 1, "R10", "sync done pulse", done_cnt, 1);

        // sync with instruction cache only
        do_launch(14, 2'd2, 8'd0, 16'd0, 3'd0, 2'b10, 1);
        chk(flush_sel_seen == 2'b10, "R8", "icache selection", flush_sel_seen, 2);

        // sync with no flags
        do_launch(15, 2'd2, 8'd0, 16'd0, 3'd0, 2'b00, 1);
        chk(flush_cnt - base_flush == 0, "R8", "empty sync no flush", flush_cnt - base_flush, 0);
        chk(done_cnt == 1, "R8", "empty sync done", done_cnt, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule